// File: doc/BRIEF.md
# Parallel Nine-Point Stencil Output Engine

This block is the compute and output stage of a lane-parallel stencil accelerator. Each clock an upstream reuse buffer may offer one tap bundle: three row slices (above, centre, below) of N+2 adjacent elements. The bundle covers columns j-1 through j+N of the neighbourhood of N output points that sit side by side in one row. The upstream buffer releases a bundle only once the row below and the column after the group have arrived. The engine therefore does not wait for look-ahead data itself. Its job is to turn every bundle into N finished grid values that leave together, in row-major order.

The engine tracks where each bundle falls in a HEIGHT by WIDTH grid. For interior points, each lane averages its nine neighbours: a fixed-point sum, then a multiply by a reciprocal constant that gives the exact integer quotient. Boundary points are the first and last rows and columns. For those, the lane passes the centre element through unchanged. Both kinds of value go through the same two register stages, so halo and computed values share one latency and form one unbroken stream. The last group of every frame carries an end-of-frame flag. The next bundle after that flag starts a new frame.

Top module: `stn9_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid and out_last are low. After reset, the next accepted bundle is treated as row 0, column group 0.
- R2: A bundle accepted on a clock edge produces out_valid exactly two clock edges later. Gaps in tap_valid appear unchanged in out_valid.
- R3: For an interior point, lane l outputs floor(S/9). S is the sum of the nine elements at slice positions l, l+1 and l+2 of tap_top, tap_mid and tap_bot. Slice position p occupies bits [p*DW +: DW].
- R4: For a halo point (row 0, row HEIGHT-1, column 0 or column WIDTH-1), lane l outputs tap_mid slice l+1 unchanged. The other taps of that lane have no effect on its output.
- R5: Bundle k of a row (k counted from 0) holds columns k*N to k*N+N-1. Lane l of the output carries column k*N+l in bits [l*DW +: DW]. Bundles are counted column group first, then row.
- R6: out_last is high exactly on the output of the bundle for row HEIGHT-1, last column group, and never while out_valid is low. The following bundle is row 0, group 0 of a new frame.
- R7: When all nine inputs hold the largest DW-bit value, the interior result is that value. The sum does not overflow and the reciprocal does not round it down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_valid | input | 1 | A tap bundle is present this cycle |
| tap_top | input | (N+2)*DW | Row above the group, columns j-1..j+N |
| tap_mid | input | (N+2)*DW | Centre row of the group, columns j-1..j+N |
| tap_bot | input | (N+2)*DW | Row below the group, columns j-1..j+N |
| out_valid | output | 1 | N output values are present |
| out_data | output | N*DW | N row-major grid values, lane 0 in the low bits |
| out_last | output | 1 | Final group of the frame |

## Verification
The hardest state to reach from the ports is a halo lane whose out-of-grid taps hold arbitrary values. In that state a wrong select, or a lane-to-column slip, would still give believable numbers. The stimulus fills every tap that falls outside the grid with fresh random data. It then checks every element of whole frames against a reference average that the bench computes itself. Further runs insert random idle cycles between bundles, send two frames back to back, and reset in the middle of a frame. These runs show that the row and column count and the end-of-frame flag follow the accepted bundles rather than clock cycles.

// File: rtl/stn9_pkg.sv
package stn9_pkg;
  // bits needed to hold the sum of nine DW-bit values
  function automatic int sum_width(input int dw);
    return dw + 4;
  endfunction

  // shift for the reciprocal of nine; four guard bits keep the quotient exact
  function automatic int recip_shift(input int dw);
    return sum_width(dw) + 4;
  endfunction
endpackage

// File: rtl/stn_pos_track.sv
module stn_pos_track #(
  parameter int N      = 4,
  parameter int WIDTH  = 16,
  parameter int HEIGHT = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [N-1:0] halo,
  output logic         frame_end
);
  localparam int GW = WIDTH / N;
  localparam int CW = $clog2(GW + 1);
  localparam int RW = $clog2(HEIGHT + 1);
  localparam logic [CW-1:0] COL_LAST = CW'(GW - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(HEIGHT - 1);

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          row_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else if (adv) begin
      if (col == COL_LAST) begin
        col <= '0;
        row <= (row == ROW_LAST) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  assign row_edge  = (row == '0) || (row == ROW_LAST);
  assign frame_end = (row == ROW_LAST) && (col == COL_LAST);

  for (genvar l = 0; l < N; l++) begin : g_halo
    localparam bit FIRST = (l == 0);
    localparam bit LAST  = (l == N - 1);
    assign halo[l] = row_edge
                   || (FIRST && (col == '0))
                   || (LAST && (col == COL_LAST));
  end
endmodule

// File: rtl/stn_lane_sum.sv
module stn_lane_sum #(
  parameter int DW = 8,
  parameter int SW = 12
) (
  input  logic [9*DW-1:0] nb,
  output logic [SW-1:0]   sum
);
  always_comb begin
    sum = '0;
    for (int k = 0; k < 9; k++) begin
      sum = sum + SW'(nb[k*DW +: DW]);
    end
  end
endmodule

// File: rtl/stn_div9.sv
module stn_div9 #(
  parameter int DW = 8,
  parameter int SW = 12,
  parameter int SH = 16
) (
  input  logic [SW-1:0] sum,
  output logic [DW-1:0] quo
);
  localparam logic [SH-1:0] RECIP = SH'(((64'd1 << SH) + 64'd8) / 64'd9);

  logic [SW+SH-1:0] prod;

  assign prod = {{SH{1'b0}}, sum} * {{SW{1'b0}}, RECIP};
  assign quo  = prod[SH +: DW];
endmodule

// File: rtl/stn9_engine.sv
module stn9_engine
  import stn9_pkg::*;
#(
  parameter int DW     = 8,
  parameter int N      = 4,
  parameter int WIDTH  = 16,
  parameter int HEIGHT = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tap_valid,
  input  logic [(N+2)*DW-1:0] tap_top,
  input  logic [(N+2)*DW-1:0] tap_mid,
  input  logic [(N+2)*DW-1:0] tap_bot,
  output logic                out_valid,
  output logic [N*DW-1:0]     out_data,
  output logic                out_last
);
  localparam int SW = sum_width(DW);
  localparam int SH = recip_shift(DW);

  logic [N-1:0]  halo_c;
  logic          end_c;

  // stage 1: neighbourhood sums, centre value and position flags
  logic          s1_valid;
  logic          s1_last;
  logic [N-1:0]  s1_halo;
  logic [SW-1:0] sum_c  [N];
  logic [SW-1:0] s1_sum [N];
  logic [DW-1:0] s1_ctr [N];

  // stage 2: selected lane values
  logic [DW-1:0] quo_c  [N];
  logic [DW-1:0] out_q  [N];

  stn_pos_track #(.N(N), .WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_pos (
    .clk       (clk),
    .rst       (rst),
    .adv       (tap_valid),
    .halo      (halo_c),
    .frame_end (end_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_last   <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      s1_valid  <= tap_valid;
      s1_last   <= tap_valid & end_c;
      out_valid <= s1_valid;
      out_last  <= s1_valid & s1_last;
    end
  end

  always_ff @(posedge clk) begin
    if (tap_valid) s1_halo <= halo_c;
  end

  for (genvar l = 0; l < N; l++) begin : g_lane
    logic [9*DW-1:0] nb;

    assign nb = {tap_bot[l*DW +: 3*DW], tap_mid[l*DW +: 3*DW], tap_top[l*DW +: 3*DW]};

    stn_lane_sum #(.DW(DW), .SW(SW)) u_sum (
      .nb  (nb),
      .sum (sum_c[l])
    );

    stn_div9 #(.DW(DW), .SW(SW), .SH(SH)) u_div (
      .sum (s1_sum[l]),
      .quo (quo_c[l])
    );

    always_ff @(posedge clk) begin
      if (tap_valid) begin
        s1_sum[l] <= sum_c[l];
        s1_ctr[l] <= tap_mid[(l+1)*DW +: DW];
      end
    end

    always_ff @(posedge clk) begin
      if (s1_valid) out_q[l] <= s1_halo[l] ? s1_ctr[l] : quo_c[l];
    end

    assign out_data[l*DW +: DW] = out_q[l];
  end
endmodule

// File: rtl/stn9_engine_chk.sv
module stn9_engine_chk #(
  parameter int DW     = 8,
  parameter int N      = 4,
  parameter int WIDTH  = 16,
  parameter int HEIGHT = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                tap_valid,
  input logic [(N+2)*DW-1:0] tap_mid,
  input logic                out_valid,
  input logic [N*DW-1:0]     out_data,
  input logic                out_last
);
  localparam int G  = (WIDTH / N) * HEIGHT;
  localparam int GB = $clog2(G + 1);

  logic [1:0]    since;
  logic [GB-1:0] out_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      since   <= '0;
      out_cnt <= '0;
    end else begin
      if (since != 2'd2) since <= since + 1'b1;
      if (out_valid) out_cnt <= (out_cnt == GB'(G - 1)) ? '0 : out_cnt + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_last));

  assert_two_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd2) |-> (out_valid == $past(tap_valid, 2)));

  assert_frame_end_R6: assert property (@(posedge clk) disable iff (rst)
    out_last == (out_valid && (out_cnt == GB'(G - 1))));

  assert_corner_halo_R4: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd2 && out_valid && out_cnt == '0)
      |-> (out_data == $past(tap_mid[DW +: N*DW], 2)));
endmodule

bind stn9_engine stn9_engine_chk #(
  .DW(DW), .N(N), .WIDTH(WIDTH), .HEIGHT(HEIGHT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tap_valid (tap_valid),
  .tap_mid   (tap_mid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/sim_stn9_engine.sv
`timescale 1ns/1ps
module sim_stn9_engine;
  localparam int DW = 8;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int H  = 6;
  localparam int GW = W / N;
  localparam int G  = GW * H;
  localparam int MAXV = (1 << DW) - 1;

  logic                clk = 1'b0;
  logic                rst;
  logic                tap_valid;
  logic [(N+2)*DW-1:0] tap_top, tap_mid, tap_bot;
  logic                out_valid;
  logic [N*DW-1:0]     out_data;
  logic                out_last;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  int grid    [2][H][W];
  int cap_dat [2*G][N];
  int cap_lst [2*G];
  int cap_cyc [2*G];
  int tap_cyc [2*G];
  int cap_n;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stn9_engine #(.DW(DW), .N(N), .WIDTH(W), .HEIGHT(H)) u0 (
    .clk(clk), .rst(rst), .tap_valid(tap_valid),
    .tap_top(tap_top), .tap_mid(tap_mid), .tap_bot(tap_bot),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      if (cap_n < 2*G) begin
        for (int l = 0; l < N; l++) cap_dat[cap_n][l] = int'(out_data[l*DW +: DW]);
        cap_lst[cap_n] = int'(out_last);
        cap_cyc[cap_n] = cyc;
      end
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int tapval(input int f, input int r, input int c);
    if (r < 0 || r >= H || c < 0 || c >= W) return int'($urandom % (MAXV + 1));
    return grid[f][r][c];
  endfunction

  task automatic fill(input int f, input int mode);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        case (mode)
          1:       grid[f][r][c] = MAXV;
          2:       grid[f][r][c] = ((r * W + c) * 7) % (MAXV + 1);
          3:       grid[f][r][c] = ((r + c) % 2 == 0) ? MAXV : 0;
          default: grid[f][r][c] = int'($urandom % (MAXV + 1));
        endcase
  endtask

  task automatic drive(input int nfr, input bit gaps);
    int idx = 0;
    for (int f = 0; f < nfr; f++)
      for (int r = 0; r < H; r++)
        for (int k = 0; k < GW; k++) begin
          if (gaps && ($urandom % 3 == 0)) begin
            @(negedge clk);
            tap_valid = 1'b0;
            repeat ($urandom % 2) @(negedge clk);
          end
          @(negedge clk);
          for (int t = 0; t < N + 2; t++) begin
            tap_top[t*DW +: DW] = DW'(tapval(f, r - 1, k*N - 1 + t));
            tap_mid[t*DW +: DW] = DW'(tapval(f, r,     k*N - 1 + t));
            tap_bot[t*DW +: DW] = DW'(tapval(f, r + 1, k*N - 1 + t));
          end
          tap_valid = 1'b1;
          tap_cyc[idx] = cyc;
          idx++;
        end
    @(negedge clk);
    tap_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic verify(input int nfr, input string vreq);
    chk(cap_n == nfr * G, "R6 output count", cap_n, nfr * G);
    for (int i = 0; i < nfr * G && i < cap_n; i++) begin
      int f = i / G;
      int q = i % G;
      int r = q / GW;
      int k = q % GW;
      for (int l = 0; l < N; l++) begin
        int c = k * N + l;
        int e;
        bit hal = (r == 0 || r == H - 1 || c == 0 || c == W - 1);
        if (hal) e = grid[f][r][c];
        else begin
          int s = 0;
          for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++) s += grid[f][r + dr][c + dc];
          e = s / 9;
        end
        chk(cap_dat[i][l] == e, hal ? "R4/R5 halo lane" : {vreq, "/R5 interior lane"},
            cap_dat[i][l], e);
      end
      chk(cap_lst[i] == ((q == G - 1) ? 1 : 0), "R6 last flag", cap_lst[i], (q == G - 1) ? 1 : 0);
      chk(cap_cyc[i] == tap_cyc[i] + 2, "R2 latency", cap_cyc[i] - tap_cyc[i], 2);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      chk(out_last == 1'b0, "R1 last after reset", int'(out_last), 0);
    end
  endtask

  task automatic t_random;
    fill(0, 0); cap_n = 0; drive(1, 1'b0); verify(1, "R3");
  endtask

  task automatic t_gaps;
    fill(0, 2); cap_n = 0; drive(1, 1'b1); verify(1, "R3 gaps");
  endtask

  task automatic t_max;
    fill(0, 1); cap_n = 0; drive(1, 1'b0); verify(1, "R7");
  endtask

  task automatic t_checker;
    fill(0, 3); cap_n = 0; drive(1, 1'b0); verify(1, "R3 checker");
  endtask

  task automatic t_back2back;
    fill(0, 0); fill(1, 2); cap_n = 0; drive(2, 1'b1); verify(2, "R3 two frames");
  endtask

  task automatic t_midreset;
    fill(0, 0);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      tap_top = {((N+2)*DW/8){8'hA5}};
      tap_mid = {((N+2)*DW/8){8'h3C}};
      tap_bot = {((N+2)*DW/8){8'h5A}};
      tap_valid = 1'b1;
    end
    @(negedge clk);
    tap_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid during reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after mid reset", int'(out_valid), 0);
    repeat (2) @(negedge clk);
    cap_n = 0;
    drive(1, 1'b0);
    verify(1, "R1 restart R3");
  endtask

  initial begin
    rst = 1'b1;
    tap_valid = 1'b0;
    tap_top = '0;
    tap_mid = '0;
    tap_bot = '0;
    cap_n = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_random();
    t_gaps();
    t_max();
    t_checker();
    t_back2back();
    t_midreset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule